// File: doc/BRIEF.md
# PCI memory burst address sequencer

This block follows the doubleword address of a PCI memory burst, whichever side of the bus it is on. The address phase is the first cycle in which FRAME# is seen low after it was high. In that cycle the block captures the AD bus. Bits 31:2 load a doubleword counter, and bits 1:0 are kept as the burst-ordering code. A data phase completes in any later cycle where IRDY# and TRDY# are both low. After each completed data phase the counter moves forward by one doubleword (4 bytes), and the current byte address is presented on a registered output. The captured ordering bits are also presented as they were received, because they take part in the address parity even though they are not a byte address.

As a target, the block supports only linear incrementing order. Any other ordering code, whether cache wrap or one of the two unused codes, is served for a single beat. After that first beat the counter freezes and a disconnect request is raised for the second data phase, so the bus logic ends the transfer without moving further data. As an initiator, the block turns a host burst request into the AD value for the address phase. It chooses the cache-wrap code only when the host burst really wraps around its cache line. Every other request gets the linear code, including bursts that start at word zero of a line and single-beat transfers.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, cur_addr is 0, cur_ad_lo is 0, burst_linear is 1, disc_req is 0 and init_valid is 0.
- R2: On an address phase (FRAME# low in a cycle after a cycle with FRAME# high), cur_addr becomes {ad_in[31:2], 2'b00} and cur_ad_lo becomes ad_in[1:0] one clock later.
- R3: The ordering code ad_in[1:0] = 2'b00 means linear, and burst_linear is then 1. The codes 2'b10 (cache wrap), 2'b01 and 2'b11 are non-linear, and burst_linear is then 0.
- R4: In a linear burst, each cycle after the address phase with irdy_n = 0 and trdy_n = 0 raises cur_addr by 4 one clock later. This includes the final phase, where frame_n is already 1.
- R5: A cycle where irdy_n or trdy_n is 1 leaves cur_addr unchanged (wait states).
- R6: The address counter wraps modulo 2^32: from 0xFFFFFFFC it advances to 0x00000000.
- R7: In a non-linear burst, the first completed data phase advances cur_addr by 4, and disc_req becomes 1 one clock later. Later completions do not change cur_addr.
- R8: disc_req stays 1 until a cycle with frame_n = 1 and irdy_n = 1 (bus idle), and clears one clock after that cycle. disc_req is never 1 while burst_linear is 1.
- R9: One clock after host_req is high, init_valid is 1 for that single cycle, with init_ad[31:2] = host_dw.
- R10: init_ad[1:0] is 2'b10 when host_wrap = 1, host_len > 1 and host_dw[2:0] (the word offset in an 8-doubleword line) is nonzero. In every other case it is 2'b00, including a word-zero aligned start and host_len = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | FRAME#, active low |
| irdy_n | input | 1 | IRDY#, active low |
| trdy_n | input | 1 | TRDY#, active low |
| ad_in | input | 32 | AD bus as observed |
| host_req | input | 1 | Host burst request strobe (initiator side) |
| host_dw | input | 30 | Host start doubleword address |
| host_len | input | 4 | Host burst length in beats |
| host_wrap | input | 1 | Host burst uses wrap-around line order |
| cur_addr | output | 32 | Current byte address of the burst |
| cur_ad_lo | output | 2 | AD[1:0] captured at the address phase |
| burst_linear | output | 1 | Current burst uses linear order |
| disc_req | output | 1 | Disconnect request for a non-linear burst |
| init_ad | output | 32 | AD value to drive in the initiator's address phase |
| init_valid | output | 1 | init_ad was updated this cycle |

## Verification
The bench builds the block with its default parameters: a 32-bit address, 8-doubleword lines and a 4-bit length field. With the 32-bit address, a burst that starts at 0xFFFFFFF8 crosses the top of the address space within three beats, so the wrap of the counter can be reached. With the 8-doubleword line, every offset case of the initiator encoder is reached with small host addresses. The wrap, unaligned-start and single-beat cases all fall within one line.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  typedef enum logic [1:0] {
    ORD_LINEAR = 2'b00,
    ORD_RSV_A  = 2'b01,
    ORD_WRAP   = 2'b10,
    ORD_RSV_B  = 2'b11
  } ord_code_e;

  function automatic logic ord_is_linear(input logic [1:0] code);
    return code == ORD_LINEAR;
  endfunction
endpackage

// File: rtl/bsq_phase_det.sv
module bsq_phase_det (
  input  logic clk,
  input  logic rst,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic trdy_n,
  output logic addr_start,
  output logic xfer,
  output logic bus_idle
);
  logic frame_q;

  always_ff @(posedge clk) begin
    if (rst) frame_q <= 1'b1;
    else     frame_q <= frame_n;
  end

  always_comb begin
    addr_start = frame_q & ~frame_n;
    xfer       = ~irdy_n & ~trdy_n & ~addr_start;
    bus_idle   = frame_n & irdy_n;
  end
endmodule

// File: rtl/bsq_addr_track.sv
module bsq_addr_track #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_start,
  input  logic              xfer,
  input  logic              bus_idle,
  input  logic [ADDR_W-1:0] ad_in,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [1:0]        cur_ad_lo,
  output logic              burst_linear,
  output logic              disc_req
);
  import bsq_pkg::*;
  localparam int DW_W = ADDR_W - 2;

  logic [DW_W-1:0] dw_q;
  logic [1:0]      code_q;
  logic            active_q;
  logic            first_done_q;
  logic            disc_q;
  logic            lin_q;
  logic            advance;

  always_comb begin
    advance = active_q & xfer & (lin_q | ~first_done_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dw_q         <= '0;
      code_q       <= ORD_LINEAR;
      lin_q        <= 1'b1;
      active_q     <= 1'b0;
      first_done_q <= 1'b0;
      disc_q       <= 1'b0;
    end else if (addr_start) begin
      dw_q         <= ad_in[ADDR_W-1:2];
      code_q       <= ad_in[1:0];
      lin_q        <= ord_is_linear(ad_in[1:0]);
      active_q     <= 1'b1;
      first_done_q <= 1'b0;
      disc_q       <= 1'b0;
    end else begin
      if (advance) begin
        dw_q         <= dw_q + 1'b1;
        first_done_q <= 1'b1;
        if (!lin_q) disc_q <= 1'b1;
      end
      if (bus_idle) begin
        active_q <= 1'b0;
        disc_q   <= 1'b0;
      end
    end
  end

  assign cur_addr     = {dw_q, 2'b00};
  assign cur_ad_lo    = code_q;
  assign burst_linear = lin_q;
  assign disc_req     = disc_q;
endmodule

// File: rtl/bsq_init_enc.sv
module bsq_init_enc #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BEATS = 8,
  parameter int LEN_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic [ADDR_W-3:0] host_dw,
  input  logic [LEN_W-1:0]  host_len,
  input  logic              host_wrap,
  output logic [ADDR_W-1:0] init_ad,
  output logic              init_valid
);
  import bsq_pkg::*;
  localparam int OFS_W = (LINE_BEATS > 1) ? $clog2(LINE_BEATS) : 1;

  logic       wraps;
  logic [1:0] code;

  always_comb begin
    wraps = host_wrap && (host_len > LEN_W'(1)) && (host_dw[OFS_W-1:0] != '0);
    code  = wraps ? ORD_WRAP : ORD_LINEAR;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      init_ad    <= '0;
      init_valid <= 1'b0;
    end else begin
      init_valid <= host_req;
      if (host_req) init_ad <= {host_dw, code};
    end
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BEATS = 8,
  parameter int LEN_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic              trdy_n,
  input  logic [ADDR_W-1:0] ad_in,
  input  logic              host_req,
  input  logic [ADDR_W-3:0] host_dw,
  input  logic [LEN_W-1:0]  host_len,
  input  logic              host_wrap,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [1:0]        cur_ad_lo,
  output logic              burst_linear,
  output logic              disc_req,
  output logic [ADDR_W-1:0] init_ad,
  output logic              init_valid
);
  logic addr_start, xfer, bus_idle;

  bsq_phase_det u_phase (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .addr_start(addr_start), .xfer(xfer), .bus_idle(bus_idle)
  );

  bsq_addr_track #(.ADDR_W(ADDR_W)) u_track (
    .clk(clk), .rst(rst), .addr_start(addr_start), .xfer(xfer),
    .bus_idle(bus_idle), .ad_in(ad_in), .cur_addr(cur_addr),
    .cur_ad_lo(cur_ad_lo), .burst_linear(burst_linear), .disc_req(disc_req)
  );

  bsq_init_enc #(.ADDR_W(ADDR_W), .LINE_BEATS(LINE_BEATS), .LEN_W(LEN_W)) u_enc (
    .clk(clk), .rst(rst), .host_req(host_req), .host_dw(host_dw),
    .host_len(host_len), .host_wrap(host_wrap), .init_ad(init_ad),
    .init_valid(init_valid)
  );
endmodule

// File: rtl/bsq_chk.sv
module bsq_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_n,
  input logic              irdy_n,
  input logic              trdy_n,
  input logic [ADDR_W-1:0] ad_in,
  input logic              host_req,
  input logic [ADDR_W-3:0] host_dw,
  input logic [LEN_W-1:0]  host_len,
  input logic              host_wrap,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [1:0]        cur_ad_lo,
  input logic              burst_linear,
  input logic              disc_req,
  input logic [ADDR_W-1:0] init_ad,
  input logic              init_valid
);
  logic fq;
  logic seen;
  always_ff @(posedge clk) begin
    if (rst) begin fq <= 1'b1; seen <= 1'b0; end
    else begin fq <= frame_n; seen <= 1'b1; end
  end
  wire astart = fq & ~frame_n;

  assert_addr_load_R2: assert property (@(posedge clk) disable iff (rst)
    astart |=> (cur_addr == {$past(ad_in[ADDR_W-1:2]), 2'b00}) && (cur_ad_lo == $past(ad_in[1:0])));

  assert_wait_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (seen && !astart && (irdy_n || trdy_n)) |=> $stable(cur_addr));

  assert_linear_no_disc_R8: assert property (@(posedge clk) disable iff (rst)
    burst_linear |-> !disc_req);

  assert_code_match_R3: assert property (@(posedge clk) disable iff (rst)
    burst_linear == (cur_ad_lo == 2'b00));

  assert_init_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    host_req |=> init_valid && (init_ad[ADDR_W-1:2] == $past(host_dw)));

  assert_init_code_R10: assert property (@(posedge clk) disable iff (rst)
    init_valid |-> (init_ad[1:0] == 2'b00 || init_ad[1:0] == 2'b10));
endmodule

bind burst_addr_seq bsq_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/burst_addr_seq_tb.sv
`timescale 1ns/1ps
module burst_addr_seq_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        frame_n, irdy_n, trdy_n;
  logic [31:0] ad_in;
  logic        host_req;
  logic [29:0] host_dw;
  logic [3:0]  host_len;
  logic        host_wrap;
  logic [31:0] cur_addr;
  logic [1:0]  cur_ad_lo;
  logic        burst_linear, disc_req;
  logic [31:0] init_ad;
  logic        init_valid;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  burst_addr_seq u_dut (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .ad_in(ad_in), .host_req(host_req), .host_dw(host_dw), .host_len(host_len),
    .host_wrap(host_wrap), .cur_addr(cur_addr), .cur_ad_lo(cur_ad_lo),
    .burst_linear(burst_linear), .disc_req(disc_req), .init_ad(init_ad),
    .init_valid(init_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic f, input logic i, input logic t, input logic [31:0] a);
    frame_n = f; irdy_n = i; trdy_n = t; ad_in = a;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    cyc(1'b1, 1'b1, 1'b1, 32'h0);
  endtask

  task automatic t_reset();
    chk("R1 cur_addr", cur_addr, 32'h0);
    chk("R1 cur_ad_lo", {30'h0, cur_ad_lo}, 32'h0);
    chk("R1 burst_linear", {31'h0, burst_linear}, 32'h1);
    chk("R1 disc_req", {31'h0, disc_req}, 32'h0);
    chk("R1 init_valid", {31'h0, init_valid}, 32'h0);
  endtask

  task automatic t_linear();
    idle();
    cyc(1'b0, 1'b1, 1'b1, 32'h0000_1230);
    chk("R2 load", cur_addr, 32'h0000_1230);
    chk("R3 linear", {31'h0, burst_linear}, 32'h1);
    cyc(1'b0, 1'b0, 1'b0, 32'hDEAD_BEEF);
    chk("R4 beat1", cur_addr, 32'h0000_1234);
    cyc(1'b0, 1'b0, 1'b1, 32'h0);
    chk("R5 trdy wait", cur_addr, 32'h0000_1234);
    cyc(1'b0, 1'b1, 1'b0, 32'h0);
    chk("R5 irdy wait", cur_addr, 32'h0000_1234);
    cyc(1'b0, 1'b0, 1'b0, 32'h0);
    chk("R4 beat2", cur_addr, 32'h0000_1238);
    cyc(1'b1, 1'b0, 1'b0, 32'h0);
    chk("R4 last beat", cur_addr, 32'h0000_123C);
    chk("R8 linear no disc", {31'h0, disc_req}, 32'h0);
    idle();
    chk("R5 idle hold", cur_addr, 32'h0000_123C);
  endtask

  task automatic t_rollover();
    idle();
    cyc(1'b0, 1'b1, 1'b1, 32'hFFFF_FFF8);
    cyc(1'b0, 1'b0, 1'b0, 32'h0);
    chk("R6 pre", cur_addr, 32'hFFFF_FFFC);
    cyc(1'b1, 1'b0, 1'b0, 32'h0);
    chk("R6 wrap", cur_addr, 32'h0000_0000);
    idle();
  endtask

  task automatic t_nonlinear(input logic [1:0] code);
    idle();
    cyc(1'b0, 1'b1, 1'b1, 32'h0000_4400 | {30'h0, code});
    chk("R2 code", {30'h0, cur_ad_lo}, {30'h0, code});
    chk("R3 nonlinear", {31'h0, burst_linear}, 32'h0);
    chk("R2 addr", cur_addr, 32'h0000_4400);
    chk("R8 no disc yet", {31'h0, disc_req}, 32'h0);
    cyc(1'b0, 1'b0, 1'b0, 32'h0);
    chk("R7 first beat", cur_addr, 32'h0000_4404);
    chk("R7 disc set", {31'h0, disc_req}, 32'h1);
    cyc(1'b0, 1'b0, 1'b0, 32'h0);
    chk("R7 frozen", cur_addr, 32'h0000_4404);
    chk("R8 disc held", {31'h0, disc_req}, 32'h1);
    cyc(1'b1, 1'b0, 1'b1, 32'h0);
    chk("R8 held until idle", {31'h0, disc_req}, 32'h1);
    idle();
    chk("R8 disc cleared", {31'h0, disc_req}, 32'h0);
  endtask

  task automatic t_init(input logic [29:0] dw, input logic [3:0] len,
                        input logic wr, input logic [1:0] exp_code);
    host_req = 1'b1; host_dw = dw; host_len = len; host_wrap = wr;
    @(posedge clk); @(negedge clk);
    host_req = 1'b0;
    chk("R9 valid", {31'h0, init_valid}, 32'h1);
    chk("R10 ad", init_ad, {dw, exp_code});
    @(posedge clk); @(negedge clk);
    chk("R9 single pulse", {31'h0, init_valid}, 32'h0);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; frame_n = 1'b1; irdy_n = 1'b1; trdy_n = 1'b1; ad_in = '0;
    host_req = 1'b0; host_dw = '0; host_len = '0; host_wrap = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_linear();
    t_rollover();
    t_nonlinear(2'b10);
    t_nonlinear(2'b01);
    t_nonlinear(2'b11);
    t_init(30'h0000_0103, 4'd8, 1'b1, 2'b10);
    t_init(30'h0000_0100, 4'd8, 1'b1, 2'b00);
    t_init(30'h0000_0105, 4'd1, 1'b1, 2'b00);
    t_init(30'h0000_0105, 4'd4, 1'b0, 2'b00);
    t_init(30'h3FFF_FFFF, 4'd2, 1'b1, 2'b10);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule